// File: doc/BRIEF.md
# Power Mode Wake-up Controller

This block keeps track of which of four operating modes the system is in. From highest to lowest power the modes are Fullspeed, Standby, Suspend and Hibernate. It also decides when the system leaves a low-power mode. Software asks for a mode and chooses which wake sources may end a sleep, using a small register interface with separate write and read ports. When the system enters Hibernate, the block removes core-domain power one cycle later. When a wake source fires, the block turns core power back on and then waits a fixed power-good interval before it reports Fullspeed. A wake never passes through an intermediate mode.

There are five wake sources, numbered by their status bit:

| Bit | Source | Activation |
|-----|--------|------------|
| 0 | Modem carrier-detect pin | Falling edge (active-low) |
| 1 | Power button pin | Rising edge |
| 2 | RTC alarm | Synchronous one-cycle pulse |
| 3 | GPIO lines (16 of them) | Rising edge on any line |
| 4 | Card interrupt pin | Falling edge (active-low) |

Each pin source passes through a two-flop synchronizer and an activation-edge detector. Every activation is recorded in a sticky status register. A wake request is raised when a status bit is set and its enable bit is also set. An RTC reset pulse wakes the block from any sleep mode, whatever the enable bits say.

Top module: `pwr_wake_ctrl`

Register addresses:

| Address | Register | Access |
|---------|----------|--------|
| 0 | Mode | Write requests a mode; read returns the current mode |
| 1 | Wake enable | Read/write |
| 2 | Wake status | Read; write-one-to-clear |

Mode codes are: 0 = Fullspeed, 1 = Standby, 2 = Suspend, 3 = Hibernate.

## Requirements
- R1: After reset, the mode output is 0 (Fullspeed), core_pwr_en is 1, and the wake status register (address 2) reads 0.
- R2: In Fullspeed, writing code 1 or 2 to address 0 changes the mode output to that code on the next cycle, and core_pwr_en stays 1 in Standby and in Suspend.
- R3: Standby or Suspend returns to mode 0 one cycle after an enabled status bit is set. Writing code 0 to address 0 also returns to mode 0.
- R4: In Fullspeed, with no enabled status bit pending, writing code 3 shows mode 3 on the next cycle and drops core_pwr_en one cycle after that.
- R5: A write of code 3 while an enabled status bit is pending is ignored, and the mode stays 0.
- R6: A pin activation sets its status bit three clock edges after the pin changes. Pins 0 and 4 activate on a falling edge, and pin 1 activates on a rising edge. Releasing a pin sets no bit.
- R7: Status bits stay set until software writes 1 to them at address 2. The cleared bits read 0 on the next cycle.
- R8: A status bit whose enable bit (address 1, same position) is 0 is still recorded, but it causes no wake.
- R9: When Hibernate sees an enabled wake, the next cycle enters a power-up phase. core_pwr_en returns one cycle after that. The mode output shows 3 for 16 cycles and then shows 0 directly.
- R10: An RTC reset pulse in Hibernate starts the same power-up sequence, even when all enable bits are 0.
- R11: Mode writes made during Hibernate or the power-up phase are ignored.
- R12: A rising edge on any one of the 16 GPIO lines sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 5 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 5 | Read data (combinational) |
| cd_n | input | 1 | Carrier-detect pin, active-low |
| pwr_btn | input | 1 | Power button pin |
| rtc_alarm | input | 1 | RTC alarm pulse |
| gpio | input | 16 | General-purpose wake lines |
| card_irq_n | input | 1 | Card interrupt pin, active-low |
| rtc_rst | input | 1 | RTC reset indication pulse |
| mode_o | output | 2 | Current mode code |
| core_pwr_en | output | 1 | Core-domain power enable |

## Verification
The assertions take three things for granted about the inputs:
- rtc_alarm and rtc_rst are single-cycle pulses that are synchronous to clk.
- A pin held at one level produces no further activations.
- Register writes last exactly one cycle.

The stimulus stays within these limits. It drives every input at the falling clock edge and raises each pulse for one cycle only. It holds every pin level for many cycles before releasing it. It also clears the status bits before each sleep entry, unless it is deliberately testing the ignored Hibernate write.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int SRC_N = 5;

  // Status bit positions, one per wake source.
  localparam int SRC_CD    = 0;
  localparam int SRC_BTN   = 1;
  localparam int SRC_ALARM = 2;
  localparam int SRC_GPIO  = 3;
  localparam int SRC_CARD  = 4;

  // Mode codes, ordered from highest to lowest power.
  localparam logic [1:0] MODE_FULL = 2'd0;
  localparam logic [1:0] MODE_STBY = 2'd1;
  localparam logic [1:0] MODE_SUSP = 2'd2;
  localparam logic [1:0] MODE_HIB  = 2'd3;

  // Register addresses.
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // ST_WAKE is the power-good wait after a Hibernate wake.
  typedef enum logic [2:0] {
    ST_FULL,
    ST_STBY,
    ST_SUSP,
    ST_HIB,
    ST_WAKE
  } st_t;
endpackage

// File: rtl/pwr_wake_sync.sv
// Brings W pins into the clock domain through two flops, then
// flags the cycle on which each pin becomes active.
module pwr_wake_sync #(
  parameter int W = 1,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] act_pulse
);
  logic [W-1:0] act_raw;
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;
  logic [W-1:0] prev_q;

  // Invert active-low pins so the rest of the logic sees active-high.
  assign act_raw = pin ^ {W{ACT_LOW}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= act_raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign act_pulse = s2_q & ~prev_q;
endmodule

// File: rtl/pwr_wake_status.sv
// Sticky status register. A new event wins over a clear
// in the same cycle, so no activation is lost.
module pwr_wake_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat_q
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | event_i;
    end
  end
endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
#(
  parameter int PG_DELAY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_req,
  input  logic       wake_req,
  input  logic       rtc_rst,
  output st_t        state_q,
  output logic [1:0] mode_o,
  output logic       core_pwr_en
);
  localparam int CW = (PG_DELAY > 1) ? $clog2(PG_DELAY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PG_DELAY - 1);

  st_t           state_d;
  logic [CW-1:0] cnt_q;
  logic          pwr_q;
  logic          wake_any;

  assign wake_any = wake_req | rtc_rst;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FULL: begin
        if (mode_we) begin
          unique case (mode_req)
            MODE_STBY: state_d = ST_STBY;
            MODE_SUSP: state_d = ST_SUSP;
            MODE_HIB:  state_d = wake_req ? ST_FULL : ST_HIB;
            default:   state_d = ST_FULL;
          endcase
        end
      end
      ST_STBY, ST_SUSP: begin
        if (wake_any || (mode_we && mode_req == MODE_FULL)) begin
          state_d = ST_FULL;
        end
      end
      ST_HIB: begin
        if (wake_any) begin
          state_d = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_FULL;
        end
      end
      default: state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FULL;
      cnt_q   <= '0;
      pwr_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_WAKE) ? cnt_q + 1'b1 : '0;
      pwr_q   <= (state_q != ST_HIB);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STBY:        mode_o = MODE_STBY;
      ST_SUSP:        mode_o = MODE_SUSP;
      ST_HIB, ST_WAKE: mode_o = MODE_HIB;
      default:        mode_o = MODE_FULL;
    endcase
  end

  assign core_pwr_en = pwr_q;
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int GPIO_W   = 16,
  parameter int PG_DELAY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [SRC_N-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [SRC_N-1:0]  rd_data,
  input  logic              cd_n,
  input  logic              pwr_btn,
  input  logic              rtc_alarm,
  input  logic [GPIO_W-1:0] gpio,
  input  logic              card_irq_n,
  input  logic              rtc_rst,
  output logic [1:0]        mode_o,
  output logic              core_pwr_en
);
  localparam int HI_W = GPIO_W + 1;

  logic [1:0]       lo_pulse;
  logic [HI_W-1:0]  hi_pulse;
  logic [SRC_N-1:0] src_event;
  logic [SRC_N-1:0] en_q;
  logic [SRC_N-1:0] stat;
  logic             wake_req;
  st_t              fsm_state;

  // Active-low pins: bit 0 is carrier detect, bit 1 is the card interrupt.
  pwr_wake_sync #(.W(2), .ACT_LOW(1'b1)) u_sync_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       ({card_irq_n, cd_n}),
    .act_pulse (lo_pulse)
  );

  // Active-high pins: the GPIO lines, plus the power button at the top bit.
  pwr_wake_sync #(.W(HI_W), .ACT_LOW(1'b0)) u_sync_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       ({pwr_btn, gpio}),
    .act_pulse (hi_pulse)
  );

  always_comb begin
    src_event            = '0;
    src_event[SRC_CD]    = lo_pulse[0];
    src_event[SRC_CARD]  = lo_pulse[1];
    src_event[SRC_BTN]   = hi_pulse[HI_W-1];
    src_event[SRC_GPIO]  = |hi_pulse[GPIO_W-1:0];
    src_event[SRC_ALARM] = rtc_alarm;
  end

  pwr_wake_status #(.N(SRC_N)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (src_event),
    .clr_we   (wr_en && wr_addr == ADDR_STAT),
    .clr_mask (wr_data),
    .stat_q   (stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en && wr_addr == ADDR_EN) begin
      en_q <= wr_data;
    end
  end

  assign wake_req = |(stat & en_q);

  pwr_wake_fsm #(.PG_DELAY(PG_DELAY)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we     (wr_en && wr_addr == ADDR_MODE),
    .mode_req    (wr_data[1:0]),
    .wake_req    (wake_req),
    .rtc_rst     (rtc_rst),
    .state_q     (fsm_state),
    .mode_o      (mode_o),
    .core_pwr_en (core_pwr_en)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_MODE: rd_data = {{(SRC_N-2){1'b0}}, mode_o};
      ADDR_EN:   rd_data = en_q;
      ADDR_STAT: rd_data = stat;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk
  import pwr_wake_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       core_pwr_en,
  input st_t        st,
  input logic       wake_req
);
  // R4: power stays off while Hibernate is held.
  p_pwr_off_hib_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_HIB && st == ST_HIB) |-> !core_pwr_en);

  // R2: power stays on in the light sleep modes.
  p_pwr_on_light_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STBY || st == ST_SUSP) |-> core_pwr_en);

  // R5: a pending enabled wake blocks entry to Hibernate.
  p_no_hib_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FULL && wake_req) |=> st != ST_HIB);

  // R9: Hibernate is left only through the power-up phase.
  p_hib_exit_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_HIB && st != ST_HIB) |-> st == ST_WAKE);

  // R9: the power-up phase still reports Hibernate.
  p_wake_shows_hib_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE) |-> mode_o == MODE_HIB);

  // R9: the power-up phase ends only in Fullspeed.
  p_wake_to_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_WAKE && st != ST_WAKE) |-> st == ST_FULL);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_o      (mode_o),
  .core_pwr_en (core_pwr_en),
  .st          (fsm_state),
  .wake_req    (wake_req)
);

// File: tb/pwr_wake_ctrl_test.sv
module pwr_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [4:0]  wr_data = '0;
  logic [1:0]  rd_addr = 2'd2;
  logic [4:0]  rd_data;
  logic        cd_n = 1'b1;
  logic        pwr_btn = 1'b0;
  logic        rtc_alarm = 1'b0;
  logic [15:0] gpio = '0;
  logic        card_irq_n = 1'b1;
  logic        rtc_rst = 1'b0;
  logic [1:0]  mode_o;
  logic        core_pwr_en;

  pwr_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cd_n(cd_n), .pwr_btn(pwr_btn),
    .rtc_alarm(rtc_alarm), .gpio(gpio), .card_irq_n(card_irq_n), .rtc_rst(rtc_rst),
    .mode_o(mode_o), .core_pwr_en(core_pwr_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Each scoreboard entry names the output to check (0 = mode,
  // 1 = core power, 2 = read data), the cycle to check it in,
  // the expected value and the requirement it covers.
  typedef struct {
    int    due;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: at each falling edge, compare every entry that is due.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        int act;
        case (q[i].kind)
          0:       act = int'(mode_o);
          1:       act = int'(core_pwr_en);
          default: act = int'(rd_data);
        endcase
        n_chk++;
        if (act != q[i].val) begin
          n_bad++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                   q[i].tag, q[i].kind, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  // Queue an expectation n rising edges from now.
  task automatic expect_at(input int n, input int kind, input int val, input string tag);
    exp_t e;
    e.due  = cyc + n;
    e.kind = kind;
    e.val  = val;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a register write for exactly one cycle.
  task automatic reg_wr(input logic [1:0] a, input logic [4:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    reg_wr(2'd2, 5'h1F);
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state.
    expect_at(1, 0, 0, "R1");
    expect_at(1, 1, 1, "R1");
    expect_at(1, 2, 0, "R1");
    tick(2);
    reg_wr(2'd1, 5'h1F);

    // R2: enter Standby; R3/R6: the power button wakes it.
    expect_at(1, 0, 1, "R2");
    expect_at(1, 1, 1, "R2");
    reg_wr(2'd0, 5'd1);
    tick(2);
    expect_at(3, 2, 5'h02, "R6");
    expect_at(3, 0, 1, "R3");
    expect_at(4, 0, 0, "R3");
    pwr_btn = 1'b1;
    tick(6);
    pwr_btn = 1'b0;
    tick(5);
    // R6: releasing the button sets nothing. R7: write-one-to-clear.
    expect_at(0 + 1, 2, 0, "R7");
    reg_wr(2'd2, 5'h02);
    tick(2);

    // R2: enter Suspend; R3: a write of code 0 leaves it.
    expect_at(1, 0, 2, "R2");
    expect_at(1, 1, 1, "R2");
    reg_wr(2'd0, 5'd2);
    tick(3);
    expect_at(1, 0, 0, "R3");
    reg_wr(2'd0, 5'd0);
    tick(2);

    // R4: enter Hibernate.
    expect_at(1, 0, 3, "R4");
    expect_at(1, 1, 1, "R4");
    expect_at(2, 1, 0, "R4");
    reg_wr(2'd0, 5'd3);
    tick(3);
    // R11: a mode write during Hibernate is ignored.
    expect_at(1, 0, 3, "R11");
    expect_at(3, 0, 3, "R11");
    reg_wr(2'd0, 5'd0);
    tick(3);
    // R12/R9: GPIO line 11 wakes Hibernate.
    expect_at(3, 2, 5'h08, "R12");
    expect_at(4, 1, 0, "R9");
    expect_at(5, 1, 1, "R9");
    expect_at(19, 0, 3, "R9");
    expect_at(20, 0, 0, "R9");
    gpio[11] = 1'b1;
    tick(4);
    // R11: a mode write during the power-up phase is ignored.
    reg_wr(2'd0, 5'd1);
    tick(22);
    gpio[11] = 1'b0;
    tick(4);
    clear_all();

    // R8: a disabled source is recorded but does not wake.
    reg_wr(2'd1, 5'h04);
    reg_wr(2'd0, 5'd3);
    tick(2);
    expect_at(3, 2, 5'h01, "R6");
    expect_at(6, 0, 3, "R8");
    expect_at(6, 1, 0, "R8");
    cd_n = 1'b0;
    tick(8);
    // R10: an RTC reset wakes regardless of the enable bits.
    reg_wr(2'd1, 5'h00);
    expect_at(1, 1, 0, "R10");
    expect_at(2, 1, 1, "R10");
    expect_at(16, 0, 3, "R10");
    expect_at(17, 0, 0, "R10");
    rtc_rst = 1'b1;
    tick(1);
    rtc_rst = 1'b0;
    tick(20);
    cd_n = 1'b1;
    tick(4);
    clear_all();

    // R5: with the card interrupt pending, a Hibernate write is ignored.
    reg_wr(2'd1, 5'h1F);
    expect_at(3, 2, 5'h10, "R6");
    card_irq_n = 1'b0;
    tick(5);
    expect_at(1, 0, 0, "R5");
    expect_at(2, 0, 0, "R5");
    expect_at(2, 1, 1, "R5");
    reg_wr(2'd0, 5'd3);
    tick(2);
    card_irq_n = 1'b1;
    tick(4);
    expect_at(1, 2, 0, "R7");
    reg_wr(2'd2, 5'h10);
    // R6: the release stays unrecorded.
    expect_at(4, 2, 0, "R6");
    tick(5);

    // R9: the alarm wakes Hibernate.
    reg_wr(2'd0, 5'd3);
    tick(3);
    expect_at(1, 2, 5'h04, "R9");
    expect_at(3, 1, 1, "R9");
    expect_at(17, 0, 3, "R9");
    expect_at(18, 0, 0, "R9");
    rtc_alarm = 1'b1;
    tick(1);
    rtc_alarm = 1'b0;
    tick(20);
    clear_all();

    // R12: the edge lines 0 and 15 both map to status bit 3.
    expect_at(3, 2, 5'h08, "R12");
    gpio[0] = 1'b1;
    gpio[15] = 1'b1;
    tick(5);

    while (q.size() != 0) tick(1);
    done = 1'b1;
  end

  initial begin
    int w = 0;
    while (!done && w < WATCHDOG) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule